// File: doc/BRIEF.md
# Shared-Bus Address Decoder with Claim Checking

This block sits in the middle of a shared fetch/store bus. One master at a time presents a request made of an address, an operation (fetch or store) and, for stores, a data word. The request goes out to four slave interfaces over a shared address and data path. Each slave owns an inclusive address window set by a base and a limit parameter, and unpopulated gaps may lie between the windows. All four windows are compared with the address at once. When exactly one window holds it, that slave alone is selected, and its acknowledge and read data are passed back to the master.

When no window holds the address, or when two or more windows hold it, the request is answered as a bus error. The decoder raises a one-cycle completion with the error flag and zero read data, and it selects no slave, so an erroring store changes nothing anywhere. The master keeps its request stable until it sees the completion and then withdraws it. Only one request is outstanding at a time.

Top module: `shared_bus_decoder`

## Requirements
- R1: A fetch (`m_fetch`=1, `m_store`=0) to an address held by exactly one window selects that slave. The completion comes back on `m_done` in the same cycle as that slave's `s_ack`, and `m_rdata` then carries that slave's read data. `m_fetch` and `m_store` are never both 1.
- R2: A store (`m_store`=1) to an address held by exactly one window selects that slave with `s_we`=1. The address and data are passed on unchanged on `s_addr`/`s_wdata`, and `m_rdata` stays zero at its completion.
- R3: Bit i of `s_sel` selects slave i, and at most one bit is set. A window claims an address when base <= address <= limit, so both the base and the limit are claimed and the addresses just outside them are not.
- R4: A request whose address lies in no window completes one cycle after it first appears, with `m_done`=1, `m_err`=1 and `m_rdata`=0.
- R5: A request whose address lies in two or more windows completes in the same way as R4.
- R6: While an erroring request is present, `s_sel` is all zero, so an erroring store leaves every slave's contents unchanged.
- R7: The error completion lasts exactly one cycle, even when the request is still held in the following cycle.
- R8: With no request present, `s_sel` is zero and `m_done` and `m_err` stay low. After reset the same holds.
- R9: The completion latency of a claimed request follows the slave: `m_done` waits for the owning slave's acknowledge, however many cycles that takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_fetch | input | 1 | Master requests a fetch (read) |
| m_store | input | 1 | Master requests a store (write) |
| m_addr | input | ADDR_W | Request address |
| m_wdata | input | DATA_W | Store data |
| m_done | output | 1 | Request completed this cycle |
| m_err | output | 1 | Completion is a bus error |
| m_rdata | output | DATA_W | Fetch data at completion, zero otherwise |
| s_sel | output | N_SLV | One-hot select, bit i for slave i |
| s_we | output | 1 | Selected access is a store |
| s_addr | output | ADDR_W | Address broadcast to slaves |
| s_wdata | output | DATA_W | Store data broadcast to slaves |
| s_ack | input | N_SLV | Per-slave completion acknowledge |
| s_rdata | input | N_SLV*DATA_W | Per-slave read data, slave i at bits i*DATA_W upward |

## Verification
An error completion is due exactly one cycle after the request is first driven. A claimed request completes in the cycle its slave acknowledges, and the bench's slave i acknowledges i+1 cycles after it is selected, so each slave has its own due cycle. The driver stamps each expected completion with its start cycle and pushes it into a queue. At every falling edge where `m_done` is high, the monitor pops the entry and compares the error flag, the read data and the elapsed cycles. On every cycle a request is active, the monitor also compares `s_sel` with the one-hot owner or with zero. One held erroring request is sampled in the cycle after its error pulse to confirm that the pulse does not repeat.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;

  // Widest slave count the helpers accept; callers zero-extend to it.
  localparam int unsigned MAX_SLV = 32;

  typedef enum logic [1:0] {
    CLAIM_NONE = 2'd0,
    CLAIM_ONE  = 2'd1,
    CLAIM_MANY = 2'd2
  } claim_e;

  // Inclusive window test on zero-extended 32-bit operands.
  function automatic logic addr_in_window(input logic [31:0] addr,
                                          input logic [31:0] base,
                                          input logic [31:0] limit);
    return (addr >= base) && (addr <= limit);
  endfunction

  // Number of set bits in a claim vector.
  function automatic int unsigned count_claims(input logic [MAX_SLV-1:0] hits);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_SLV; i++) begin
      n += 32'(hits[i]);
    end
    return n;
  endfunction

  // Fold a claim count into the three outcomes the decoder acts on.
  function automatic claim_e classify(input int unsigned n);
    if (n == 0) return CLAIM_NONE;
    if (n == 1) return CLAIM_ONE;
    return CLAIM_MANY;
  endfunction

endpackage

// File: rtl/bus_range_match.sv
module bus_range_match
  import bus_dec_pkg::*;
#(
  parameter int N_SLV  = 4,
  parameter int ADDR_W = 16,
  parameter logic [N_SLV*ADDR_W-1:0] SLV_BASE  = '0,
  parameter logic [N_SLV*ADDR_W-1:0] SLV_LIMIT = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_SLV-1:0]  hit
);

  // One comparator pair per slave, all evaluated in parallel.
  for (genvar g = 0; g < N_SLV; g++) begin : g_win
    localparam logic [ADDR_W-1:0] WIN_LO = SLV_BASE[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] WIN_HI = SLV_LIMIT[g*ADDR_W +: ADDR_W];
    assign hit[g] = addr_in_window(32'(addr), 32'(WIN_LO), 32'(WIN_HI));
  end

endmodule

// File: rtl/bus_claim_resolve.sv
module bus_claim_resolve
  import bus_dec_pkg::*;
#(
  parameter int N_SLV = 4
) (
  input  logic             req,
  input  logic [N_SLV-1:0] hit,
  output claim_e           claim,
  output logic [N_SLV-1:0] owner
);

  int unsigned n_claims;

  always_comb begin
    n_claims = count_claims(MAX_SLV'(hit));
    claim    = classify(n_claims);
    // Only a clean single claim reaches a slave; anything else stays quiet.
    owner    = (req && (claim == CLAIM_ONE)) ? hit : '0;
  end

endmodule

// File: rtl/bus_err_responder.sv
module bus_err_responder (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic bad,
  output logic err_pulse
);

  logic err_q;

  // Answer a bad request one cycle after it appears; the self-clear
  // keeps the answer to one cycle while the master withdraws.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= req & bad & ~err_q;
  end

  assign err_pulse = err_q;

  // R7: an error answer never lasts two cycles
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  // R4: a fresh bad request is answered on the next cycle
  a_r4_err_due: assert property (@(posedge clk) disable iff (!rst_n)
    (req && bad && !err_pulse) |=> err_pulse);

endmodule

// File: rtl/bus_return_mux.sv
module bus_return_mux #(
  parameter int N_SLV  = 4,
  parameter int DATA_W = 32
) (
  input  logic [N_SLV-1:0]        owner,
  input  logic                    is_fetch,
  input  logic [N_SLV-1:0]        s_ack,
  input  logic [N_SLV*DATA_W-1:0] s_rdata,
  output logic                    done,
  output logic [DATA_W-1:0]       rdata
);

  // AND-OR return path: at most one owner bit is set.
  always_comb begin
    done  = 1'b0;
    rdata = '0;
    for (int i = 0; i < N_SLV; i++) begin
      if (owner[i] && s_ack[i]) begin
        done = 1'b1;
        if (is_fetch) rdata = rdata | s_rdata[i*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/shared_bus_decoder.sv
module shared_bus_decoder
  import bus_dec_pkg::*;
#(
  parameter int N_SLV  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [N_SLV*ADDR_W-1:0] SLV_BASE  = {16'h8000, 16'h4000, 16'h1000, 16'h0000},
  parameter logic [N_SLV*ADDR_W-1:0] SLV_LIMIT = {16'h8FFF, 16'h4FFF, 16'h1FFF, 16'h0FFF}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    m_fetch,
  input  logic                    m_store,
  input  logic [ADDR_W-1:0]       m_addr,
  input  logic [DATA_W-1:0]       m_wdata,
  output logic                    m_done,
  output logic                    m_err,
  output logic [DATA_W-1:0]       m_rdata,
  output logic [N_SLV-1:0]        s_sel,
  output logic                    s_we,
  output logic [ADDR_W-1:0]       s_addr,
  output logic [DATA_W-1:0]       s_wdata,
  input  logic [N_SLV-1:0]        s_ack,
  input  logic [N_SLV*DATA_W-1:0] s_rdata
);

  // Named internal events, used by the logic and by the assertions.
  logic             req;
  logic [N_SLV-1:0] hit;
  claim_e           claim;
  logic [N_SLV-1:0] owner;
  logic             claim_bad;
  logic             slv_done;
  logic [DATA_W-1:0] slv_rdata;
  logic             err_pulse;

  assign req       = m_fetch | m_store;
  assign claim_bad = (claim != CLAIM_ONE);

  bus_range_match #(
    .N_SLV(N_SLV), .ADDR_W(ADDR_W),
    .SLV_BASE(SLV_BASE), .SLV_LIMIT(SLV_LIMIT)
  ) u_match (
    .addr(m_addr),
    .hit (hit)
  );

  bus_claim_resolve #(.N_SLV(N_SLV)) u_resolve (
    .req  (req),
    .hit  (hit),
    .claim(claim),
    .owner(owner)
  );

  bus_err_responder u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .bad      (claim_bad),
    .err_pulse(err_pulse)
  );

  bus_return_mux #(.N_SLV(N_SLV), .DATA_W(DATA_W)) u_ret (
    .owner   (owner),
    .is_fetch(m_fetch),
    .s_ack   (s_ack),
    .s_rdata (s_rdata),
    .done    (slv_done),
    .rdata   (slv_rdata)
  );

  // Slave side: shared address/data, private selects.
  assign s_sel   = owner;
  assign s_we    = m_store;
  assign s_addr  = m_addr;
  assign s_wdata = m_wdata;

  // Master side: slave completion or decoder-generated error.
  assign m_done  = slv_done | err_pulse;
  assign m_err   = err_pulse;
  assign m_rdata = slv_rdata;

  // R1: the master never asks for both operations at once
  a_r1_op_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_fetch && m_store));

  // R3: never more than one slave selected
  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_sel));

  // R6: unclaimed or multiply claimed requests reach no slave
  a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req && claim_bad) |-> (s_sel == '0));

  // R4: an error completion carries zero data
  a_r4_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> (m_done && (m_rdata == '0)));

  // R8: no request, no select
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (s_sel == '0));

  // R9: a routed request completes exactly when its owner acknowledges
  a_r9_done_tracks_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((|s_sel) && !m_err) |-> (m_done == (|(s_ack & s_sel))));

  // R2: store completions return no data
  a_r2_store_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (m_store && m_done) |-> (m_rdata == '0));

endmodule

// File: tb/sim_shared_bus_decoder.sv
module sim_shared_bus_decoder;

  localparam int NS = 4;
  localparam logic [15:0] WLO [NS] = '{16'h0000, 16'h1000, 16'h4000, 16'h4800};
  localparam logic [15:0] WHI [NS] = '{16'h0FFF, 16'h1FFF, 16'h4FFF, 16'h5FFF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        m_fetch = 1'b0, m_store = 1'b0;
  logic [15:0] m_addr = '0;
  logic [31:0] m_wdata = '0;
  logic        m_done, m_err;
  logic [31:0] m_rdata;
  logic [NS-1:0] s_sel;
  logic        s_we;
  logic [15:0] s_addr;
  logic [31:0] s_wdata;
  logic [NS-1:0] s_ack;
  logic [NS*32-1:0] s_rdata;

  shared_bus_decoder #(
    .N_SLV(NS), .ADDR_W(16), .DATA_W(32),
    .SLV_BASE ({16'h4800, 16'h4000, 16'h1000, 16'h0000}),
    .SLV_LIMIT({16'h5FFF, 16'h4FFF, 16'h1FFF, 16'h0FFF})
  ) u0 (
    .clk(clk), .rst_n(rst_n), .m_fetch(m_fetch), .m_store(m_store),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_done(m_done), .m_err(m_err),
    .m_rdata(m_rdata), .s_sel(s_sel), .s_we(s_we), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_ack(s_ack), .s_rdata(s_rdata)
  );

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] seed_word(input int s, input int w);
    return 32'hA000_0000 + 32'(s << 8) + 32'(w);
  endfunction

  // Slave models: slave i acknowledges i+1 cycles after being selected.
  logic [NS-1:0] ack_r;
  int            wait_c [NS];
  logic [31:0]   smem [NS][16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_r <= '0;
      for (int i = 0; i < NS; i++) begin
        wait_c[i] <= 0;
        for (int j = 0; j < 16; j++) smem[i][j] <= seed_word(i, j);
      end
    end else begin
      for (int i = 0; i < NS; i++) begin
        if (s_sel[i] && !ack_r[i]) begin
          if (wait_c[i] == i) begin ack_r[i] <= 1'b1; wait_c[i] <= 0; end
          else wait_c[i] <= wait_c[i] + 1;
        end else begin
          ack_r[i] <= 1'b0;
          wait_c[i] <= 0;
        end
        if (ack_r[i] && s_sel[i] && s_we) smem[i][s_addr[5:2]] <= s_wdata;
      end
    end
  end

  assign s_ack = ack_r;
  always_comb begin
    for (int i = 0; i < NS; i++) s_rdata[i*32 +: 32] = smem[i][s_addr[5:2]];
  end

  // Bench-side view of the map and of slave contents.
  logic [31:0] shadow [NS][16];

  function automatic int who_claims(input logic [15:0] a, output int owner);
    int n;
    n = 0;
    owner = -1;
    for (int i = 0; i < NS; i++) begin
      if (a >= WLO[i] && a <= WHI[i]) begin n++; owner = i; end
    end
    return n;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  typedef struct {
    logic        err;
    logic [31:0] rdata;
    int          lat;
    int          start;
    string       rq;
  } exp_t;

  exp_t exp_q[$];

  // Driver state the monitor reads.
  bit     active = 0, cur_bad = 0, cur_st = 0;
  int     cur_owner = 0;
  logic [15:0] cur_addr = '0;

  task automatic do_req(input bit st, input logic [15:0] a, input logic [31:0] d,
                        input string rq, input bit hold);
    exp_t e;
    int own, n;
    n = who_claims(a, own);
    e.err   = (n != 1);
    e.rdata = (!e.err && !st) ? shadow[own][a[5:2]] : 32'h0;
    e.lat   = e.err ? 1 : own + 1;
    e.rq    = rq;
    @(posedge clk); #1;
    m_fetch = !st; m_store = st; m_addr = a; m_wdata = d;
    cur_bad = e.err; cur_st = st; cur_owner = own; cur_addr = a;
    e.start = cyc;
    exp_q.push_back(e);
    active = 1;
    do @(negedge clk); while (!m_done);
    if (!e.err && st) shadow[own][a[5:2]] = d;
    if (hold) begin
      @(negedge clk);
      check(!m_done && !m_err, "R7", "held error request repeats", {30'b0, m_done, m_err}, 32'h0);
      #1;
    end else begin
      @(posedge clk); #1;
    end
    active = 0;
    m_fetch = 0; m_store = 0;
  endtask

  // Monitor: completions against the queue, selects against the owner.
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_done) begin
        if (exp_q.size() == 0) begin
          check(0, "R8", "completion with nothing pending", 32'(m_done), 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(m_err == e.err, e.rq, "error flag", 32'(m_err), 32'(e.err));
          check(m_rdata == e.rdata, e.rq, "read data", m_rdata, e.rdata);
          check((cyc - e.start) == e.lat, "R9", "completion latency",
                32'(cyc - e.start), 32'(e.lat));
        end
      end
      if (active) begin
        if (cur_bad)
          check(s_sel == '0, "R6", "select during error", 32'(s_sel), 32'h0);
        else begin
          check(s_sel == NS'(1 << cur_owner), "R3", "owner select", 32'(s_sel), 32'(1 << cur_owner));
          check(s_we == cur_st && s_addr == cur_addr, "R2", "shared path",
                {15'b0, s_we, s_addr}, {15'b0, cur_st, cur_addr});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++)
      for (int j = 0; j < 16; j++) shadow[i][j] = seed_word(i, j);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!m_done && !m_err && s_sel == '0, "R8", "reset state",
          {27'b0, s_sel, m_done}, 32'h0);

    do_req(0, 16'h0000, '0, "R1", 0);          // slave 0 base
    do_req(0, 16'h0FFF, '0, "R3", 0);          // slave 0 limit
    do_req(0, 16'h1000, '0, "R3", 0);          // slave 1 base, one past slave 0
    do_req(0, 16'h1FFF, '0, "R3", 0);          // slave 1 limit
    do_req(1, 16'h1004, 32'hDEAD_0001, "R2", 0);
    do_req(0, 16'h1004, '0, "R2", 0);          // store visible on readback
    do_req(0, 16'h2000, '0, "R4", 0);          // one past slave 1: hole
    do_req(0, 16'h3FFF, '0, "R4", 0);          // top of hole
    do_req(0, 16'hFFFF, '0, "R4", 0);          // unpopulated top
    do_req(0, 16'h47FC, '0, "R1", 0);          // slave 2 only
    do_req(0, 16'h5000, '0, "R1", 0);          // slave 3 only
    do_req(0, 16'h4800, '0, "R5", 0);          // overlap low edge
    do_req(0, 16'h4FFF, '0, "R5", 0);          // overlap high edge
    do_req(1, 16'h4808, 32'hBAD0_0002, "R6", 0);  // erroring store
    do_req(1, 16'h3008, 32'hBAD0_0003, "R6", 0);  // store into hole
    do_req(0, 16'h4008, '0, "R6", 0);          // slave 2 word 2 untouched
    do_req(0, 16'h5008, '0, "R6", 0);          // slave 3 word 2 untouched
    do_req(0, 16'h0008, '0, "R6", 0);          // slave 0 word 2 untouched
    do_req(1, 16'h5FFC, 32'h1234_5678, "R2", 0);
    do_req(0, 16'h5FFC, '0, "R9", 0);
    do_req(0, 16'h4C00, '0, "R7", 1);          // held overlap request
    do_req(1, 16'h2004, 32'h0BAD_0004, "R7", 1);  // held hole store

    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!m_done && !m_err && s_sel == '0, "R8", "idle bus",
            {27'b0, s_sel, m_done}, 32'h0);
    end
    check(exp_q.size() == 0, "R9", "pending completions", 32'(exp_q.size()), 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule